// File: doc/BRIEF.md
# FIFO Programmable Threshold Offset Loader

This block keeps the two threshold offsets that a FIFO flag generator compares against its fill level: the almost-empty offset and the almost-full offset. A mode input is captured on every clock while master reset is held. It picks one of two programming paths, a bit-serial shift path or a word-wide parallel path. It also picks the default offsets that master reset loads into both registers.

Once reset is released, software or a controller can rewrite the offsets as often as it likes through the path chosen at reset. Strobes on the path that was not chosen are ignored. Reading the offsets back always goes through the parallel read strobe, and the two registers are returned in alternating order. The two offset values leave the block as plain outputs that feed the flag comparator.

Top module: `fifo_thresh_loader`

## Requirements
- R1: `load_sel` is captured on every rising clock edge where `mrst` is high: 1 selects serial programming and 0 selects parallel programming, shown on `serial_mode` (1 = serial). Changes of `load_sel` while `mrst` is low have no effect.
- R2: A reset edge with `load_sel` = 1 sets both `ae_ofs` and `af_ofs` to 0x3FF (1023).
- R3: A reset edge with `load_sel` = 0 sets both `ae_ofs` and `af_ofs` to 0x07F (127).
- R4: In serial mode, each clock edge with `ser_en` high writes `ser_in` into the next offset bit. The order is LSB first, with `ae_ofs` bits 0..9 first and then `af_ofs` bits 0..9. After the 20th bit the position wraps back to `ae_ofs` bit 0.
- R5: In parallel mode, successive `par_wr` strobes write `par_wdata` into `ae_ofs` and then into `af_ofs`, and this order repeats.
- R6: A `par_rd` strobe, in either mode, places a register value on `par_rdata` at the next clock edge. Successive strobes return `ae_ofs`, then `af_ofs`, and repeat. The value returned is the one held before any write on the same edge.
- R7: `par_wr` in serial mode and `ser_en` in parallel mode change neither offset and do not move any write position.
- R8: Every master reset reloads the defaults and returns the serial bit position and both parallel order pointers to the almost-empty register. It also clears `par_rdata` to 0.
- R9: After reset, offsets can be rewritten any number of times, and each new write replaces the value held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst | input | 1 | Synchronous master reset, active high |
| load_sel | input | 1 | Programming mode select, captured during reset (1 = serial) |
| ser_en | input | 1 | Serial shift enable |
| ser_in | input | 1 | Serial data bit |
| par_wr | input | 1 | Parallel write strobe |
| par_wdata | input | 10 | Parallel write word |
| par_rd | input | 1 | Parallel read strobe |
| par_rdata | output | 10 | Registered readback word |
| ae_ofs | output | 10 | Almost-empty offset to the flag generator |
| af_ofs | output | 10 | Almost-full offset to the flag generator |
| serial_mode | output | 1 | Captured programming mode (1 = serial) |

## Verification
The in-line assertions check on every cycle that:
- the reset defaults follow the captured mode;
- the mode stays fixed outside reset;
- the offsets hold when the strobe that matches the mode is idle, including under mismatched strobes;
- the serial bit position stays in range and wraps;
- each parallel pointer toggles exactly on its strobe.

Only the bench's scenarios can show the things that depend on bit placement and data values. These are:
- that each serial bit lands in the correct bit of the correct register, LSB first;
- that readback returns the value held before a write on the same edge;
- that a reset in the middle of a sequence restarts the write order.

The bench does this with directed sequences and seeded random traffic, checked against a reference model.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
   typedef enum logic {
      PM_PARALLEL = 1'b0,
      PM_SERIAL   = 1'b1
   } prog_mode_e;

   typedef enum logic {
      SEL_AE = 1'b0,
      SEL_AF = 1'b1
   } ofs_sel_e;
endpackage

// File: rtl/ofs_ser_ctl.sv
module ofs_ser_ctl
   import ofs_pkg::*;
#(
   parameter int W = 10
) (
   input  logic                 clk,
   input  logic                 mrst,
   input  logic                 go,
   output ofs_sel_e             sel,
   output logic [$clog2(W)-1:0] bit_idx
);
   localparam int TOTAL = 2 * W;
   localparam int CW    = $clog2(TOTAL);
   localparam int IW    = $clog2(W);
   localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);
   localparam logic [CW-1:0] HALF = CW'(W);

   logic [CW-1:0] cnt;
   logic [CW-1:0] rel;

   always_ff @(posedge clk) begin
      if (mrst)    cnt <= '0;
      else if (go) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end

   always_comb begin
      sel     = (cnt >= HALF) ? SEL_AF : SEL_AE;
      rel     = (sel == SEL_AF) ? (cnt - HALF) : cnt;
      bit_idx = rel[IW-1:0];
   end

   p_cnt_range_r4: assert property (@(posedge clk) disable iff (mrst)
      cnt <= LAST);
   p_wrap_r4: assert property (@(posedge clk) disable iff (mrst)
      (go && cnt == LAST) |=> (cnt == '0));
   p_hold_r7: assert property (@(posedge clk) disable iff (mrst)
      !go |=> $stable(cnt));
endmodule

// File: rtl/ofs_par_ctl.sv
module ofs_par_ctl
   import ofs_pkg::*;
#(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         mrst,
   input  logic         wr_go,
   input  logic         rd_go,
   input  logic [W-1:0] ae_q,
   input  logic [W-1:0] af_q,
   output ofs_sel_e     wsel,
   output logic [W-1:0] rdata
);
   ofs_sel_e rsel;

   always_ff @(posedge clk) begin
      if (mrst) begin
         wsel  <= SEL_AE;
         rsel  <= SEL_AE;
         rdata <= '0;
      end else begin
         if (wr_go) wsel <= (wsel == SEL_AE) ? SEL_AF : SEL_AE;
         if (rd_go) begin
            rdata <= (rsel == SEL_AF) ? af_q : ae_q;
            rsel  <= (rsel == SEL_AE) ? SEL_AF : SEL_AE;
         end
      end
   end

   p_wr_alt_r5: assert property (@(posedge clk) disable iff (mrst)
      wr_go |=> (wsel != $past(wsel)));
   p_wr_hold_r7: assert property (@(posedge clk) disable iff (mrst)
      !wr_go |=> $stable(wsel));
   p_rd_alt_r6: assert property (@(posedge clk) disable iff (mrst)
      rd_go |=> (rsel != $past(rsel)));
   p_rd_hold_r6: assert property (@(posedge clk) disable iff (mrst)
      !rd_go |=> ($stable(rsel) && $stable(rdata)));
endmodule

// File: rtl/ofs_reg.sv
module ofs_reg #(
   parameter int W = 10
) (
   input  logic                 clk,
   input  logic                 mrst,
   input  logic [W-1:0]         dflt,
   input  logic                 bit_we,
   input  logic [$clog2(W)-1:0] bit_idx,
   input  logic                 bit_val,
   input  logic                 word_we,
   input  logic [W-1:0]         word_val,
   output logic [W-1:0]         q
);
   always_ff @(posedge clk) begin
      if (mrst)         q          <= dflt;
      else if (word_we) q          <= word_val;
      else if (bit_we)  q[bit_idx] <= bit_val;
   end

   p_one_src_r7: assert property (@(posedge clk) disable iff (mrst)
      !(bit_we && word_we));
endmodule

// File: rtl/fifo_thresh_loader.sv
module fifo_thresh_loader
   import ofs_pkg::*;
#(
   parameter int         W        = 10,
   parameter logic [9:0] SER_DFLT = 10'h3FF,
   parameter logic [9:0] PAR_DFLT = 10'h07F
) (
   input  logic         clk,
   input  logic         mrst,
   input  logic         load_sel,
   input  logic         ser_en,
   input  logic         ser_in,
   input  logic         par_wr,
   input  logic [W-1:0] par_wdata,
   input  logic         par_rd,
   output logic [W-1:0] par_rdata,
   output logic [W-1:0] ae_ofs,
   output logic [W-1:0] af_ofs,
   output logic         serial_mode
);
   localparam int IW    = $clog2(W);
   localparam int NREG  = 2;
   localparam logic [W-1:0] SER_D = W'(SER_DFLT);
   localparam logic [W-1:0] PAR_D = W'(PAR_DFLT);

   if (W < 8 || W > 32) begin : g_bad_width
      $error("fifo_thresh_loader: W must lie in 8..32");
   end

   prog_mode_e       mode;
   ofs_sel_e         ser_sel;
   ofs_sel_e         par_sel;
   logic [IW-1:0]    ser_idx;
   logic             ser_go;
   logic             wr_go;
   logic [W-1:0]     dflt;
   logic [W-1:0]     q [NREG];

   always_ff @(posedge clk) begin
      if (mrst) mode <= load_sel ? PM_SERIAL : PM_PARALLEL;
   end

   always_comb begin
      ser_go      = ser_en && (mode == PM_SERIAL);
      wr_go       = par_wr && (mode == PM_PARALLEL);
      dflt        = load_sel ? SER_D : PAR_D;
      serial_mode = (mode == PM_SERIAL);
      ae_ofs      = q[SEL_AE];
      af_ofs      = q[SEL_AF];
   end

   ofs_ser_ctl #(.W(W)) u_ser (
      .clk     (clk),
      .mrst    (mrst),
      .go      (ser_go),
      .sel     (ser_sel),
      .bit_idx (ser_idx)
   );

   ofs_par_ctl #(.W(W)) u_par (
      .clk   (clk),
      .mrst  (mrst),
      .wr_go (wr_go),
      .rd_go (par_rd),
      .ae_q  (q[SEL_AE]),
      .af_q  (q[SEL_AF]),
      .wsel  (par_sel),
      .rdata (par_rdata)
   );

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      ofs_reg #(.W(W)) u_reg (
         .clk      (clk),
         .mrst     (mrst),
         .dflt     (dflt),
         .bit_we   (ser_go && (int'(ser_sel) == i)),
         .bit_idx  (ser_idx),
         .bit_val  (ser_in),
         .word_we  (wr_go && (int'(par_sel) == i)),
         .word_val (par_wdata),
         .q        (q[i])
      );
   end

   p_ser_dflt_r2: assert property (@(posedge clk)
      (mrst && load_sel) |=> (ae_ofs == SER_D && af_ofs == SER_D));
   p_par_dflt_r3: assert property (@(posedge clk)
      (mrst && !load_sel) |=> (ae_ofs == PAR_D && af_ofs == PAR_D));
   p_mode_hold_r1: assert property (@(posedge clk) disable iff (mrst)
      1'b1 |=> $stable(serial_mode));
   p_ignore_r7: assert property (@(posedge clk) disable iff (mrst)
      ((serial_mode && !ser_en) || (!serial_mode && !par_wr))
      |=> ($stable(ae_ofs) && $stable(af_ofs)));
endmodule

// File: tb/tb_fifo_thresh_loader.sv
module tb_fifo_thresh_loader;
   localparam int W = 10;

   logic         clk = 1'b0;
   logic         mrst = 1'b1;
   logic         load_sel = 1'b1;
   logic         ser_en = 1'b0;
   logic         ser_in = 1'b0;
   logic         par_wr = 1'b0;
   logic [W-1:0] par_wdata = '0;
   logic         par_rd = 1'b0;
   logic [W-1:0] par_rdata;
   logic [W-1:0] ae_ofs;
   logic [W-1:0] af_ofs;
   logic         serial_mode;

   int n_cmp = 0;
   int n_bad = 0;

   logic         m_ser;
   logic [W-1:0] m_ae, m_af, m_rd;
   int           m_cnt;
   logic         m_wp, m_rp;

   always #5 clk = ~clk;

   fifo_thresh_loader #(.W(W)) dut (
      .clk(clk), .mrst(mrst), .load_sel(load_sel), .ser_en(ser_en),
      .ser_in(ser_in), .par_wr(par_wr), .par_wdata(par_wdata),
      .par_rd(par_rd), .par_rdata(par_rdata), .ae_ofs(ae_ofs),
      .af_ofs(af_ofs), .serial_mode(serial_mode)
   );

   function automatic logic [W-1:0] dflt_of(input logic ls);
      return ls ? 10'h3FF : 10'h07F;
   endfunction

   task automatic model_edge();
      logic [W-1:0] rv;
      if (mrst) begin
         m_ser = load_sel;
         m_ae  = dflt_of(load_sel);
         m_af  = dflt_of(load_sel);
         m_cnt = 0; m_wp = 0; m_rp = 0; m_rd = '0;
      end else begin
         rv = m_rp ? m_af : m_ae;
         if (par_rd) begin m_rd = rv; m_rp = ~m_rp; end
         if (m_ser && ser_en) begin
            if (m_cnt < W) m_ae[m_cnt] = ser_in;
            else           m_af[m_cnt-W] = ser_in;
            m_cnt = (m_cnt + 1) % (2 * W);
         end
         if (!m_ser && par_wr) begin
            if (m_wp) m_af = par_wdata; else m_ae = par_wdata;
            m_wp = ~m_wp;
         end
      end
   endtask

   task automatic cmp(input string tag, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic rst, input logic ls, input logic se,
                       input logic si, input logic pw, input logic [W-1:0] wd,
                       input logic pr, input string tag);
      @(negedge clk);
      mrst = rst; load_sel = ls; ser_en = se; ser_in = si;
      par_wr = pw; par_wdata = wd; par_rd = pr;
      @(posedge clk);
      model_edge();
      #1;
      cmp(tag, "ae_ofs", ae_ofs, m_ae);
      cmp(tag, "af_ofs", af_ofs, m_af);
      cmp(tag, "par_rdata", par_rdata, m_rd);
      cmp(tag, "serial_mode", W'(serial_mode), W'(m_ser));
   endtask

   task automatic idle(input string tag);
      step(0, $urandom_range(0, 1), 0, 0, 0, '0, 0, tag);
   endtask

   task automatic shift_word(input logic [W-1:0] v, input string tag);
      for (int b = 0; b < W; b++) step(0, 1, 1, v[b], 0, '0, 0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      // R2: serial reset defaults, R1 mode capture
      step(1, 1, 0, 0, 0, '0, 0, "R2");
      step(1, 1, 0, 0, 0, '0, 0, "R1");
      idle("R1");
      // R4: LSB first, ae then af
      shift_word(10'h155, "R4");
      cmp("R4", "ae after 10 bits", ae_ofs, 10'h155);
      shift_word(10'h2AA, "R4");
      cmp("R4", "af after 20 bits", af_ofs, 10'h2AA);
      // R4 wrap: next bit lands in ae bit 0
      step(0, 1, 1, 0, 0, '0, 0, "R4");
      cmp("R4", "wrap to ae bit0", ae_ofs, 10'h154);
      // R7: parallel strobe ignored in serial mode
      step(0, 1, 0, 0, 1, 10'h0F0, 0, "R7");
      cmp("R7", "ae after ignored par_wr", ae_ofs, 10'h154);
      // R6: readback in serial mode, ae then af
      step(0, 0, 0, 0, 0, '0, 1, "R6");
      cmp("R6", "read 1", par_rdata, 10'h154);
      step(0, 1, 0, 0, 0, '0, 1, "R6");
      cmp("R6", "read 2", par_rdata, 10'h2AA);
      // R1: load_sel outside reset has no effect
      step(0, 0, 0, 0, 0, '0, 0, "R1");
      cmp("R1", "mode kept", W'(serial_mode), W'(1));
      // R9 random serial traffic
      for (int i = 0; i < 400; i++)
         step(0, $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
              $urandom_range(0,1), W'($urandom), $urandom_range(0,1), "R9");
      // R8: reset mid-sequence restarts at ae bit 0
      shift_word(10'h3C3, "R8");
      step(0, 1, 1, 1, 0, '0, 0, "R8");
      step(1, 1, 0, 0, 0, '0, 0, "R8");
      cmp("R8", "serial defaults", af_ofs, 10'h3FF);
      shift_word(10'h001, "R8");
      cmp("R8", "restart at ae", ae_ofs, 10'h001);
      // R3: parallel defaults
      step(1, 0, 0, 0, 0, '0, 0, "R3");
      cmp("R3", "ae default", ae_ofs, 10'h07F);
      cmp("R3", "af default", af_ofs, 10'h07F);
      cmp("R8", "rdata cleared", par_rdata, '0);
      step(0, 1, 0, 0, 0, '0, 0, "R1");
      cmp("R1", "parallel mode kept", W'(serial_mode), W'(0));
      // R5: alternating writes
      step(0, 0, 0, 0, 1, 10'h123, 0, "R5");
      cmp("R5", "first write ae", ae_ofs, 10'h123);
      step(0, 0, 0, 0, 1, 10'h321, 0, "R5");
      cmp("R5", "second write af", af_ofs, 10'h321);
      // R7: serial ignored in parallel mode
      step(0, 0, 1, 0, 0, '0, 0, "R7");
      cmp("R7", "ae after ignored ser_en", ae_ofs, 10'h123);
      // R6: read with same-edge write returns old value
      step(0, 0, 0, 0, 1, 10'h2B0, 1, "R6");
      cmp("R6", "old value on same edge", par_rdata, 10'h123);
      cmp("R9", "rewrite ae", ae_ofs, 10'h2B0);
      // R9 random parallel traffic
      for (int i = 0; i < 400; i++)
         step(0, $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
              $urandom_range(0,1), W'($urandom), $urandom_range(0,1), "R9");
      // R8: reset after one write restarts order at ae
      step(0, 0, 0, 0, 1, 10'h011, 0, "R8");
      step(1, 0, 0, 0, 0, '0, 0, "R8");
      step(0, 0, 0, 0, 1, 10'h222, 1, "R8");
      cmp("R8", "write order restarted", ae_ofs, 10'h222);
      cmp("R8", "read order restarted", par_rdata, 10'h07F);
      // random mix with occasional resets
      for (int i = 0; i < 600; i++)
         step($urandom_range(0,40) == 0, $urandom_range(0,1), $urandom_range(0,1),
              $urandom_range(0,1), $urandom_range(0,1), W'($urandom),
              $urandom_range(0,1), "R8");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule